// File: doc/BRIEF.md
# Flash Write Completion Status Generator

This block sits on the read path of a flash device model. While an internal program or erase runs, it gives every read a status byte instead of array data. The top bit is a polling bit. During a program it is the inverse of the top bit of the byte being written. During an erase it is zero. The bit below it is a toggle bit that inverts on each read made while busy. Once the operation ends, reads return the array data unchanged. The command decoder and the array lie outside this block. They supply the busy flag, the operation kind, the top bit of the byte being programmed and the array read data.

A host-side poller is included beside the generator. It is started with the byte the host expects to find once the operation is done (the programmed byte, or all ones after an erase). It then issues reads until the polling bit matches that byte. Completion is asynchronous to the reads, so a read can catch the operation just as it finishes. For that reason a matching polling bit only opens a confirmation step. The poller reads the location twice more and reports success only when both reads return the full expected byte. It reports a mismatch otherwise. It reports a timeout when no poll shows completion within a set number of polls. Host reads and poller reads share a single read strobe into the generator.

Top module: `wstat_top`

## Requirements
- R1: A read made while `busy` is low returns `arr_data` as sampled on the read cycle.
- R2: A read made while busy with `op_erase` low returns, in bit DATA_W-1, the inverse of `prog_top_bit`.
- R3: A read made while busy with `op_erase` high returns 0 in bit DATA_W-1.
- R4: Bit DATA_W-2 of a busy read returns a toggle flag and then inverts it. The flag is 0 after reset. Reads made while idle leave the flag unchanged.
- R5: Bits DATA_W-3 down to 0 of every busy read are 0.
- R6: After `poll_start`, the poller reports pass (`poll_result` = 1) when a poll read matches bit DATA_W-1 of the expected byte and both of the next two reads equal the whole expected byte.
- R7: The poller reports fail (`poll_result` = 2) when either confirmation read differs from the expected byte.
- R8: If none of MAX_POLLS poll reads matches, the poller reports timeout (`poll_result` = 3). `poll_done` then rises exactly 2*MAX_POLLS cycles after the cycle in which the start was sampled.
- R9: `poll_done` is a single-cycle pulse. `poll_result` is 0 after reset and holds its value until the next completion. A `poll_start` made while polling is ignored.
- R10: `bus_valid` is high in exactly the cycle after a read request, and `bus_data` changes only at such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_rd | input | 1 | Host read strobe, one per read |
| busy | input | 1 | Internal program or erase in progress |
| op_erase | input | 1 | 1 = running operation is an erase, 0 = program |
| prog_top_bit | input | 1 | Top bit of the byte being programmed |
| arr_data | input | DATA_W | Array read data |
| bus_data | output | DATA_W | Byte returned by the latest read |
| bus_valid | output | 1 | High for one cycle when bus_data holds a new read |
| poll_start | input | 1 | Starts the completion poller |
| poll_exp | input | DATA_W | Byte expected after completion, latched at start |
| poll_active | output | 1 | Poller is running |
| poll_done | output | 1 | One-cycle completion pulse |
| poll_result | output | 2 | 0 none, 1 pass, 2 fail, 3 timeout |

## Verification
A read sampled at a clock edge gives its byte and `bus_valid` right after that same edge. The bench samples inputs at each rising edge and checks the data on the following falling edge. It keeps its own toggle flag, which advances only on reads it saw issued while busy. Each poller operation costs two cycles per read. So a timeout must land exactly 2*MAX_POLLS edges after the start edge, and the bench counts those edges itself. The pass and fail outcomes are awaited under a bound and compared with the result expected from the completion byte the bench places in the array.

// File: rtl/wstat_pkg.sv
// Shared types for the write completion status block.
// Assumes: result codes are visible to software as a 2-bit value.
package wstat_pkg;
    typedef enum logic [1:0] {
        RES_NONE    = 2'd0,
        RES_PASS    = 2'd1,
        RES_FAIL    = 2'd2,
        RES_TIMEOUT = 2'd3
    } wres_e;

    typedef enum logic [1:0] {
        P_IDLE  = 2'd0,
        P_ISSUE = 2'd1,
        P_WAIT  = 2'd2
    } pstate_e;

    typedef enum logic [1:0] {
        PH_POLL  = 2'd0,
        PH_CONF1 = 2'd1,
        PH_CONF2 = 2'd2
    } phase_e;
endpackage

// File: rtl/wstat_gen.sv
// Device-side status generator. It registers one byte per read strobe.
// A busy read yields a status byte: the polling bit, the toggle bit and
// zeros below them. An idle read yields the array data.
// Assumes: busy, op_erase and prog_top_bit are stable for the whole
// operation. Array data is valid in the cycle of the read strobe.
module wstat_gen #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              busy,
    input  logic              op_erase,
    input  logic              prog_top_bit,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    logic              tog_q;
    logic [DATA_W-1:0] status;

    // Build the status byte shown while an operation is running.
    always_comb begin
        status           = '0;
        status[POLL_BIT] = op_erase ? 1'b0 : ~prog_top_bit;
        status[TOG_BIT]  = tog_q;
    end

    // Capture the read result and advance the toggle on busy reads only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            tog_q    <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                if (busy) begin
                    rd_data <= status;
                    tog_q   <= ~tog_q;
                end else begin
                    rd_data <= arr_data;
                end
            end
        end
    end

    // R1
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !busy) |=> (rd_data == $past(arr_data)));
    // R2
    prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && !op_erase) |=> (rd_data[POLL_BIT] == !$past(prog_top_bit)));
    // R3
    erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && op_erase) |=> (rd_data[POLL_BIT] == 1'b0));
    // R5
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> (rd_data[TOG_BIT-1:0] == '0));
    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && $stable(rd_data)));
endmodule

// File: rtl/wstat_poll.sv
// Host-side completion poller. After start it issues poll reads until the
// polling bit matches the expected byte, then confirms with two full-byte
// reads, because completion may land on a status read. It reports pass,
// fail or timeout.
// Assumes: each read it requests returns rd_valid in the next cycle.
module wstat_poll
    import wstat_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int MAX_POLLS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] exp_byte,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req,
    output logic              active,
    output logic              done,
    output wres_e             result
);
    localparam int POLL_BIT = DATA_W - 1;
    localparam int CNT_W    = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [CNT_W-1:0] LAST_POLL = CNT_W'(MAX_POLLS - 1);

    pstate_e           state;
    phase_e            phase;
    logic [CNT_W-1:0]  poll_cnt;
    logic [DATA_W-1:0] exp_q;
    logic              bit_match;
    logic              byte_match;

    // Compare the returned byte with the latched expectation.
    always_comb begin
        bit_match  = (rd_data[POLL_BIT] == exp_q[POLL_BIT]);
        byte_match = (rd_data == exp_q);
        rd_req     = (state == P_ISSUE);
        active     = (state != P_IDLE);
    end

    // Sequence poll reads, confirmation reads and the final verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= P_IDLE;
            phase    <= PH_POLL;
            poll_cnt <= '0;
            exp_q    <= '0;
            done     <= 1'b0;
            result   <= RES_NONE;
        end else begin
            done <= 1'b0;
            case (state)
                P_IDLE: if (start) begin
                    exp_q    <= exp_byte;
                    poll_cnt <= '0;
                    phase    <= PH_POLL;
                    state    <= P_ISSUE;
                end
                P_ISSUE: state <= P_WAIT;
                P_WAIT: if (rd_valid) begin
                    case (phase)
                        PH_POLL: begin
                            if (bit_match) begin
                                phase <= PH_CONF1;
                                state <= P_ISSUE;
                            end else if (poll_cnt == LAST_POLL) begin
                                done   <= 1'b1;
                                result <= RES_TIMEOUT;
                                state  <= P_IDLE;
                            end else begin
                                poll_cnt <= poll_cnt + 1'b1;
                                state    <= P_ISSUE;
                            end
                        end
                        PH_CONF1: begin
                            if (byte_match) begin
                                phase <= PH_CONF2;
                                state <= P_ISSUE;
                            end else begin
                                done   <= 1'b1;
                                result <= RES_FAIL;
                                state  <= P_IDLE;
                            end
                        end
                        default: begin
                            done   <= 1'b1;
                            result <= byte_match ? RES_PASS : RES_FAIL;
                            state  <= P_IDLE;
                        end
                    endcase
                end
                default: state <= P_IDLE;
            endcase
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    pass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_PASS) |-> ($past(rd_data) == exp_q));
    // R8
    timeout_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_TIMEOUT) |-> (poll_cnt == LAST_POLL));
    // R10
    wait_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == P_WAIT) |-> rd_valid);
    // R10
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
endmodule

// File: rtl/wstat_top.sv
// Top of the write completion status block. It joins the status
// generator with the host poller, and host reads and poller reads share
// the one read strobe.
// Assumes: a host read and a poller read in the same cycle count as a
// single read.
module wstat_top
    import wstat_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int MAX_POLLS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd,
    input  logic              busy,
    input  logic              op_erase,
    input  logic              prog_top_bit,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_valid,
    input  logic              poll_start,
    input  logic [DATA_W-1:0] poll_exp,
    output logic              poll_active,
    output logic              poll_done,
    output logic [1:0]        poll_result
);
    logic  poll_req;
    logic  rd_en;
    wres_e res;

    // Merge the host and poller read strobes.
    always_comb begin
        rd_en       = host_rd | poll_req;
        poll_result = res;
    end

    wstat_gen #(.DATA_W(DATA_W)) u_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_en        (rd_en),
        .busy         (busy),
        .op_erase     (op_erase),
        .prog_top_bit (prog_top_bit),
        .arr_data     (arr_data),
        .rd_data      (bus_data),
        .rd_valid     (bus_valid)
    );

    wstat_poll #(.DATA_W(DATA_W), .MAX_POLLS(MAX_POLLS)) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (poll_start),
        .exp_byte (poll_exp),
        .rd_valid (bus_valid),
        .rd_data  (bus_data),
        .rd_req   (poll_req),
        .active   (poll_active),
        .done     (poll_done),
        .result   (res)
    );
endmodule

// File: tb/tb_wstat_top.sv
// Bench for wstat_top: random host reads plus directed poller runs.
module tb_wstat_top;
    localparam int DW   = 8;
    localparam int MAXP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_rd = 1'b0, busy = 1'b0, op_erase = 1'b0, prog_top_bit = 1'b0;
    logic [DW-1:0] arr_data = '0, poll_exp = '0;
    logic          poll_start = 1'b0;
    logic [DW-1:0] bus_data;
    logic          bus_valid, poll_active, poll_done;
    logic [1:0]    poll_result;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    wstat_top #(.DATA_W(DW), .MAX_POLLS(MAXP)) dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_read(input logic bz, input logic er,
                                               input logic pt, input logic tg,
                                               input logic [DW-1:0] ar);
        logic [DW-1:0] v;
        if (!bz) return ar;
        v = '0;
        v[DW-1] = er ? 1'b0 : ~pt;
        v[DW-2] = tg;
        return v;
    endfunction

    // Inputs seen at each rising edge, for checks at the next falling edge.
    logic          hr_q = 0, bz_q = 0, er_q = 0, pt_q = 0, pa_q = 0, rs_q = 0;
    logic [DW-1:0] ar_q = '0;
    always @(posedge clk) begin
        hr_q <= host_rd; bz_q <= busy; er_q <= op_erase; pt_q <= prog_top_bit;
        ar_q <= arr_data; pa_q <= poll_active; rs_q <= rst_n;
    end

    logic tog_m = 1'b0;
    logic done_prev = 1'b0;
    always @(negedge clk) begin
        if (rs_q && rst_n) begin
            if (bus_valid) begin
                logic [DW-1:0] e;
                e = exp_read(bz_q, er_q, pt_q, tog_m, ar_q);
                if (!bz_q) chk(bus_data == e, "R1 idle read", bus_data, e);
                else begin
                    chk(bus_data[DW-1] == e[DW-1], er_q ? "R3 erase poll bit" : "R2 program poll bit",
                        bus_data[DW-1], e[DW-1]);
                    chk(bus_data[DW-2] == tog_m, "R4 toggle bit", bus_data[DW-2], tog_m);
                    chk(bus_data[DW-3:0] == '0, "R5 low bits zero", bus_data[DW-3:0], 0);
                    tog_m = ~tog_m;
                end
            end
            if (hr_q) chk(bus_valid == 1'b1, "R10 valid after host read", bus_valid, 1);
            else if (!pa_q) chk(bus_valid == 1'b0, "R10 no valid without read", bus_valid, 0);
            if (poll_done && done_prev) chk(1'b0, "R9 done pulse width", 2, 1);
            done_prev = poll_done;
        end else begin
            tog_m = 1'b0;
            done_prev = 1'b0;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // One poller run: busy clears after blen cycles and the array then shows fin.
    task automatic run_poll(input logic [DW-1:0] ex, input logic er, input logic [DW-1:0] pb,
                            input int blen, input logic [DW-1:0] fin, input int want,
                            input bit rnd_rd, input string tag);
        int cyc;
        bit seen;
        busy = 1'b1; op_erase = er; prog_top_bit = pb[DW-1];
        arr_data = DW'($urandom); poll_exp = ex; poll_start = 1'b1;
        @(posedge clk); #1;
        poll_start = 1'b0;
        cyc = 0; seen = 0;
        while (!seen && cyc < 4 * MAXP + 20) begin
            if (cyc == 2) begin poll_start = 1'b1; poll_exp = ~ex; end
            if (cyc == 3) begin poll_start = 1'b0; poll_exp = ex; end
            host_rd = rnd_rd ? ($urandom_range(3) == 0) : 1'b0;
            @(posedge clk); #1;
            cyc++;
            if (cyc == blen) begin busy = 1'b0; arr_data = fin; end
            @(negedge clk);
            if (poll_done) seen = 1;
        end
        host_rd = 1'b0;
        chk(seen, "R9 done reached", seen, 1);
        chk(int'(poll_result) == want, tag, poll_result, want);
        if (want == 3) chk(cyc == 2 * MAXP, "R8 timeout latency", cyc, 2 * MAXP);
        tick();
        chk(int'(poll_result) == want, "R9 result held", poll_result, want);
        busy = 1'b0;
        tick();
    endtask

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (3) tick();
        @(negedge clk);
        chk(bus_data == '0 && !bus_valid, "R10 reset bus", {bus_valid, bus_data}, 0);
        chk(poll_result == 2'd0 && !poll_done && !poll_active, "R9 reset poller",
            {poll_active, poll_done, poll_result}, 0);
        rst_n = 1'b1;
        tick();
        // R4 idle reads must not advance the toggle flag
        busy = 1'b0;
        repeat (5) begin host_rd = 1'b1; arr_data = DW'($urandom); tick(); end
        busy = 1'b1; op_erase = 1'b0; prog_top_bit = 1'b1;
        repeat (3) begin host_rd = 1'b1; tick(); end
        busy = 1'b0; arr_data = 8'hFF; tick();
        host_rd = 1'b0; tick();
        // Random host reads over random operations (R1..R5, R10)
        for (int i = 0; i < 400; i++) begin
            host_rd = $urandom_range(1);
            busy = ($urandom_range(2) != 0);
            op_erase = $urandom_range(1);
            prog_top_bit = $urandom_range(1);
            arr_data = DW'($urandom);
            tick();
        end
        host_rd = 1'b0; busy = 1'b0; tick(); tick();
        // Directed poller runs
        run_poll(8'h5A, 1'b0, 8'h5A, 9, 8'h5A, 1, 1'b0, "R6 program pass");
        run_poll(8'hFF, 1'b1, 8'h00, 20, 8'hFF, 1, 1'b0, "R6 erase pass");
        run_poll(8'h81, 1'b0, 8'h81, 6, 8'h80, 2, 1'b0, "R7 confirm mismatch");
        run_poll(8'h3C, 1'b0, 8'h3C, 100000, 8'h3C, 3, 1'b0, "R8 program timeout");
        run_poll(8'hFF, 1'b1, 8'h00, 100000, 8'hFF, 3, 1'b1, "R8 erase timeout");
        run_poll(8'h40, 1'b0, 8'h40, 1, 8'h40, 1, 1'b0, "R6 busy ends at once");
        // Random poller runs mixed with host reads
        for (int i = 0; i < 30; i++) begin
            logic [DW-1:0] ex;
            logic er;
            int kind;
            er = $urandom_range(1);
            ex = er ? 8'hFF : DW'($urandom);
            kind = $urandom_range(2);
            if (kind == 0)
                run_poll(ex, er, ex, $urandom_range(40, 1), ex, 1, 1'b1, "R6 random pass");
            else if (kind == 1)
                run_poll(ex, er, ex, $urandom_range(40, 1), ex ^ DW'($urandom_range(127, 1)), 2,
                         1'b1, "R7 random mismatch");
            else
                run_poll(ex, er, ex, 100000, ex, 3, 1'b1, "R8 random timeout");
        end
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule